// File: doc/BRIEF.md
# Banked Interrupt Aggregation Controller

This block gathers up to 160 interrupt request lines into five banks of 32 bits. Only 137 of those bit positions are wired to real sources. Each bank holds two registers. An enable register selects which of its sources may raise an interrupt. A sticky status register latches every source that has gone high, and software clears that latch by writing a 1 to the bit.

Banks 0 to 2 form the functional group and banks 3 and 4 form the error group. Each group drives a level-sensitive summary line. Each group also reports the number of its lowest pending enabled source, so a service routine can handle sources one at a time: it reads the number, services that source, acknowledges it, and reads the next number.

A source is numbered by bit position, not by its count among populated sources. The global number is 32 × bank + bit, so bank 3 bit 0 is number 96. The register port is a plain single-cycle port. A write takes effect at the clock edge on which `reg_we` is high, and read data is a combinational function of `reg_addr`.

Top module: `irq_bank_aggregator`

## Requirements
- R1: After reset, every enable bit and every status bit is 0, both summary lines are low, and both valid flags are low.
- R2: Word address b (0 to 4) holds the enable register of bank b, and word address 5+b holds the status register of bank b. An enable register reads back the value last written to it, with unpopulated bits forced to 0.
- R3: A status bit becomes 1 at the clock edge at which its source input is high, whether or not the source is enabled. Once set, the bit stays at 1 after the source input falls.
- R4: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If a clear and a source-high arrive on the same edge, the bit stays set.
- R5: A source counts as pending only when both its enable bit and its status bit are 1. A masked source with status set does not raise a summary line, and enabling that source later exposes its event at once.
- R6: `fn_irq_o` is the OR of pending sources in banks 0 to 2, and `err_irq_o` is the OR of pending sources in banks 3 and 4. Activity in one group never drives the other group's outputs.
- R7: The reported source number is 32 × bank + bit. For example, bank 1 bit 8 reports as 40 and bank 4 bit 2 reports as 130.
- R8: Within a group, the reported number is the lowest pending source: lower bank first, then lower bit within the bank. The group's valid flag is 1 exactly when the group has a pending source.
- R9: Populated widths per bank are 32, 32, 24, 32 and 17 bits, counted from bit 0. Unpopulated bit positions read as 0 and never set, whether driven by a source or written through the port.
- R10: Addresses 10 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 160 | Source lines; bit n is global source n |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word address (enable 0–4, status 5–9) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| fn_irq_o | output | 1 | Functional group summary, level |
| fn_vld_o | output | 1 | A functional source is pending |
| fn_src_o | output | 8 | Lowest pending functional source number |
| err_irq_o | output | 1 | Error group summary, level |
| err_vld_o | output | 1 | An error source is pending |
| err_src_o | output | 8 | Lowest pending error source number |

## Verification
The checker assumes that source lines are low during the cycle in which reset is released. It also assumes that the port's address and write data are known whenever `reg_we` is high. Under those two conditions, the sticky-capture and clear properties can compare state against the previous cycle's inputs without seeing values from before reset. The bench meets both assumptions. It holds every source at 0 through reset, and it changes sources and register-port inputs only on falling clock edges, so each input is stable across the rising edge that samples it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int AGG_NUM_BANKS = 5;
  localparam int AGG_FN_BANKS  = 3;
  localparam int AGG_BANK_W    = 32;
  localparam int AGG_ADDR_W    = 4;
  localparam int AGG_SRC_NUM_W = 8;

  // Number of wired sources in each bank, counted from bit 0.
  function automatic int agg_pop_count(input int bank);
    case (bank)
      0:       return 32;
      1:       return 32;
      2:       return 24;
      3:       return 32;
      4:       return 17;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W   = 32,
  parameter int POP = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         ctrl_we,
  input  logic         stat_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] pend
);

  localparam logic [W-1:0] MASK = (POP >= W) ? {W{1'b1}} : W'((64'd1 << POP) - 64'd1);

  logic [W-1:0] clr_vec;

  assign clr_vec = stat_we ? wdata : '0;
  assign pend    = ctrl_q & stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata & MASK;
      // A new event on the same edge overrides the clear.
      stat_q <= ((stat_q & ~clr_vec) | src) & MASK;
    end
  end

endmodule

// File: rtl/irq_lsb_enc.sv
module irq_lsb_enc #(
  parameter int W     = 96,
  parameter int BASE  = 0,
  parameter int IDX_W = 8
) (
  input  logic [W-1:0]     vec,
  output logic             vld,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    vld = |vec;
    idx = '0;
    // Scan downward so the last hit, the lowest set bit, wins.
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(BASE + i);
    end
  end

endmodule

// File: rtl/irq_bank_aggregator.sv
module irq_bank_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS = AGG_NUM_BANKS,
  parameter int FN_BANKS  = AGG_FN_BANKS,
  parameter int BANK_W    = AGG_BANK_W,
  parameter int ADDR_W    = AGG_ADDR_W,
  parameter int SRC_NUM_W = AGG_SRC_NUM_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [BANK_W-1:0]           reg_wdata,
  output logic [BANK_W-1:0]           reg_rdata,
  output logic                        fn_irq_o,
  output logic                        fn_vld_o,
  output logic [SRC_NUM_W-1:0]        fn_src_o,
  output logic                        err_irq_o,
  output logic                        err_vld_o,
  output logic [SRC_NUM_W-1:0]        err_src_o
);

  localparam int SRC_W   = NUM_BANKS * BANK_W;
  localparam int FN_W    = FN_BANKS * BANK_W;
  localparam int ERR_W   = SRC_W - FN_W;
  localparam int STAT_LO = NUM_BANKS;

  logic [SRC_W-1:0]     ctrl_flat;
  logic [SRC_W-1:0]     stat_flat;
  logic [SRC_W-1:0]     pend_flat;
  logic [NUM_BANKS-1:0] ctrl_we;
  logic [NUM_BANKS-1:0] stat_we;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign ctrl_we[b] = reg_we && (reg_addr == ADDR_W'(b));
    assign stat_we[b] = reg_we && (reg_addr == ADDR_W'(STAT_LO + b));

    irq_bank #(
      .W   (BANK_W),
      .POP (agg_pop_count(b))
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_i[b*BANK_W +: BANK_W]),
      .ctrl_we (ctrl_we[b]),
      .stat_we (stat_we[b]),
      .wdata   (reg_wdata),
      .ctrl_q  (ctrl_flat[b*BANK_W +: BANK_W]),
      .stat_q  (stat_flat[b*BANK_W +: BANK_W]),
      .pend    (pend_flat[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == ADDR_W'(b))           reg_rdata = ctrl_flat[b*BANK_W +: BANK_W];
      if (reg_addr == ADDR_W'(STAT_LO + b)) reg_rdata = stat_flat[b*BANK_W +: BANK_W];
    end
  end

  assign fn_irq_o  = |pend_flat[FN_W-1:0];
  assign err_irq_o = |pend_flat[SRC_W-1:FN_W];

  irq_lsb_enc #(
    .W     (FN_W),
    .BASE  (0),
    .IDX_W (SRC_NUM_W)
  ) u_fn_enc (
    .vec (pend_flat[FN_W-1:0]),
    .vld (fn_vld_o),
    .idx (fn_src_o)
  );

  irq_lsb_enc #(
    .W     (ERR_W),
    .BASE  (FN_W),
    .IDX_W (SRC_NUM_W)
  ) u_err_enc (
    .vec (pend_flat[SRC_W-1:FN_W]),
    .vld (err_vld_o),
    .idx (err_src_o)
  );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS = AGG_NUM_BANKS,
  parameter int FN_BANKS  = AGG_FN_BANKS,
  parameter int BANK_W    = AGG_BANK_W,
  parameter int ADDR_W    = AGG_ADDR_W,
  parameter int SRC_NUM_W = AGG_SRC_NUM_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_BANKS*BANK_W-1:0] src_i,
  input logic                        reg_we,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [BANK_W-1:0]           reg_wdata,
  input logic [BANK_W-1:0]           reg_rdata,
  input logic                        fn_irq_o,
  input logic                        fn_vld_o,
  input logic [SRC_NUM_W-1:0]        fn_src_o,
  input logic                        err_irq_o,
  input logic                        err_vld_o,
  input logic [SRC_NUM_W-1:0]        err_src_o,
  input logic [NUM_BANKS*BANK_W-1:0] ctrl_flat,
  input logic [NUM_BANKS*BANK_W-1:0] stat_flat
);

  localparam int SRC_W = NUM_BANKS * BANK_W;
  localparam int FN_W  = FN_BANKS * BANK_W;

  function automatic logic [SRC_W-1:0] build_mask();
    logic [SRC_W-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      for (int i = 0; i < BANK_W; i++)
        if (i < agg_pop_count(b)) m[b*BANK_W + i] = 1'b1;
    return m;
  endfunction

  localparam logic [SRC_W-1:0] POP_MASK = build_mask();

  // R3
  sticky_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((($past(src_i) & POP_MASK) & ~stat_flat) == '0));

  // R4
  w1c_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_we) && $past(reg_addr) == ADDR_W'(NUM_BANKS))
      |-> ((stat_flat[BANK_W-1:0] & $past(reg_wdata) & ~$past(src_i[BANK_W-1:0])) == '0));

  // R5
  fn_pending_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fn_vld_o |-> (ctrl_flat[fn_src_o] && stat_flat[fn_src_o]));

  // R5
  err_pending_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld_o |-> (ctrl_flat[err_src_o] && stat_flat[err_src_o]));

  // R6
  fn_summary_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fn_irq_o == fn_vld_o);

  // R6
  err_summary_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq_o == err_vld_o);

  // R7
  err_src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld_o |-> (int'(err_src_o) >= FN_W));

  // R9
  unpop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_flat | ctrl_flat) & ~POP_MASK) == '0);

  // R10
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= 2 * NUM_BANKS) |-> (reg_rdata == '0));

endmodule

bind irq_bank_aggregator irq_agg_chk #(
  .NUM_BANKS (NUM_BANKS),
  .FN_BANKS  (FN_BANKS),
  .BANK_W    (BANK_W),
  .ADDR_W    (ADDR_W),
  .SRC_NUM_W (SRC_NUM_W)
) u_chk (.*);

// File: tb/irq_bank_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_bank_aggregator_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [159:0] src_i = '0;
  logic         reg_we = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         fn_irq_o, fn_vld_o, err_irq_o, err_vld_o;
  logic [7:0]   fn_src_o, err_src_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_bank_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fn_irq_o(fn_irq_o), .fn_vld_o(fn_vld_o), .fn_src_o(fn_src_o),
    .err_irq_o(err_irq_o), .err_vld_o(err_vld_o), .err_src_o(err_src_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(addr); reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    reg_addr = 4'(addr);
    #0.5;
    data = reg_rdata;
  endtask

  task automatic pulse(input logic [159:0] bits);
    @(negedge clk);
    src_i = bits;
    @(negedge clk);
    src_i = '0;
  endtask

  task automatic clean();
    for (int b = 0; b < 5; b++) begin
      wr(b, 32'h0);
      wr(5 + b, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 10; a++) begin
      rd(a, d);
      check("R1 reg zero", d, 32'h0);
    end
    check("R1 summaries", {28'h0, fn_irq_o, fn_vld_o, err_irq_o, err_vld_o}, 32'h0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] d;
    wr(0, 32'hA5A5_5A5A); rd(0, d); check("R2 ctrl0 readback", d, 32'hA5A5_5A5A);
    wr(2, 32'hFFFF_FFFF); rd(2, d); check("R9 ctrl2 width", d, 32'h00FF_FFFF);
    wr(4, 32'hFFFF_FFFF); rd(4, d); check("R9 ctrl4 width", d, 32'h0001_FFFF);
    rd(5, d); check("R2 stat0 separate", d, 32'h0);
    clean();
  endtask

  task automatic t_sticky_mask();
    logic [31:0] d;
    pulse(160'h1 << 5);
    rd(5, d); check("R3 masked capture sticky", d, 32'h20);
    check("R5 masked no irq", {31'h0, fn_irq_o}, 32'h0);
    wr(0, 32'h20);
    check("R5 enable exposes", {31'h0, fn_irq_o}, 32'h1);
    check("R7 bank0 number", {24'h0, fn_src_o}, 32'd5);
    check("R6 err unaffected", {31'h0, err_irq_o}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(5, 32'h0); rd(5, d); check("R4 write zero keeps", d, 32'h20);
    wr(5, 32'h20); rd(5, d); check("R4 w1c clears", d, 32'h0);
    check("R8 vld low when idle", {31'h0, fn_vld_o}, 32'h0);
    @(negedge clk);
    src_i = 160'h1 << 5; reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h20;
    @(negedge clk);
    src_i = '0; reg_we = 1'b0;
    rd(5, d); check("R4 set wins over clear", d, 32'h20);
    clean();
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);
    pulse((160'h1 << 70) | (160'h1 << 40) | (160'h1 << 130));
    check("R8 fn lowest bank first", {24'h0, fn_src_o}, 32'd40);
    check("R7 err bank4 number", {24'h0, err_src_o}, 32'd130);
    check("R6 both summaries", {30'h0, fn_irq_o, err_irq_o}, 32'h3);
    wr(6, 32'h100);
    check("R7 bank2 number", {24'h0, fn_src_o}, 32'd70);
    pulse((160'h1 << 100) | (160'h1 << 103));
    check("R8 err lowest bit", {24'h0, err_src_o}, 32'd100);
    wr(8, 32'hFFFF_FFFF);
    check("R8 err falls to bank4", {24'h0, err_src_o}, 32'd130);
    wr(7, 32'h40);
    check("R6 fn clear", {31'h0, fn_irq_o}, 32'h0);
    wr(9, 32'h4);
    check("R6 err clear", {31'h0, err_irq_o}, 32'h0);
    rd(9, d); check("R4 stat4 cleared", d, 32'h0);
    clean();
  endtask

  task automatic t_unpop();
    logic [31:0] d;
    for (int b = 0; b < 5; b++) wr(b, 32'hFFFF_FFFF);
    pulse({{15{1'b1}}, 49'h0, {8{1'b1}}, 88'h0});
    rd(7, d); check("R9 bank2 upper never sets", d, 32'h0);
    rd(9, d); check("R9 bank4 upper never sets", d, 32'h0);
    check("R9 no pending", {30'h0, fn_vld_o, err_vld_o}, 32'h0);
    clean();
  endtask

  task automatic t_hole();
    logic [31:0] d;
    wr(1, 32'h1234_5678);
    wr(12, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    rd(12, d); check("R10 hole reads zero", d, 32'h0);
    rd(1, d);  check("R10 ctrl1 untouched", d, 32'h1234_5678);
    rd(0, d);  check("R10 ctrl0 untouched", d, 32'h0);
    rd(5, d);  check("R10 stat0 untouched", d, 32'h0);
    clean();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_sticky_mask();
    t_w1c();
    t_priority();
    t_unpop();
    t_hole();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule